// File: doc/BRIEF.md
# Parallel Host Mailbox Slave

This block sits on the peripheral side of an 8-bit asynchronous parallel bus. An external host reaches a local processor through eight one-byte mailboxes. Each mailbox has two data paths, one per direction, and each path has a full flag. The host never sees a clock. It picks a mailbox with three select lines, qualifies the access with an active-low chip select, and marks the transfer with strobes. A local configuration bit sets how the strobes are read. The block only answers host strobes and never starts a bus cycle of its own.

All host inputs pass through two-flop synchronizers. Every host action takes effect at the rising edge of the strobe that ends the access, as seen after synchronization. A host write fills a host-to-local mailbox and raises its flag. A local read of that mailbox clears the flag. The return path works the same way: a local write fills a local-to-host mailbox and raises its flag, and a host read clears it. The flags drive two interrupts: a level interrupt to the host and a request to the local CPU.

The local side is a plain synchronous register port. There is no stream handshake on either side, so the bus carries no back-pressure. The host is expected to pace its writes by waiting for the local CPU's reply or interrupt. If the host writes a mailbox that is still full, the new byte overwrites the old one.

Top module: `pbus_mailbox`

## Requirements
- R1: After reset, all flags, masks and the control register read 0, the data output enable is low, `hb_irq_n` is 1 and `lc_irq` is 0.
- R2: With control bit 1 = 0 and bit 0 = 1, a host write happens when `hb_cs_n` rises while `hb_stba_n` is low (the stba pin acts as write enable). The byte on `hb_data_i` is stored in host-to-local mailbox `hb_sel` and sets bit `hb_sel` of the host-to-local flag register.
- R3: In the same mode, holding `hb_cs_n` low with `hb_stba_n` high drives local-to-host mailbox `hb_sel` onto `hb_data_o` with `hb_data_oe` = 1, within 3 clocks. When `hb_cs_n` rises, that mailbox's local-to-host flag clears.
- R4: With control bit 1 = 1, `hb_stba_n` is a write strobe and `hb_stbb_n` is a read strobe. A rising write strobe stores data, a low read strobe drives the bus, and a rising read strobe clears the flag. Each strobe acts only while `hb_cs_n` is low; with `hb_cs_n` high, strobes change nothing and the bus is not driven.
- R5: A local read at address 0..7 returns that host-to-local mailbox byte on `lc_rdata` one clock later and clears its flag.
- R6: A local write at address 0..7 stores the byte in that local-to-host mailbox and sets its flag.
- R7: `lc_irq` = control bit 2 AND (any bit set in host-to-local flags AND host-to-local mask).
- R8: `hb_irq_n` is low exactly when control bit 0 is 1 and some local-to-host flag is set under the local-to-host mask.
- R9: With control bit 0 = 0, the data bus is never driven and host strobes change no flag and no mailbox.
- R10: A host write and a local read of the same mailbox in the same clock leave the flag set. The local read returns the old byte, and the new byte stays in the mailbox.
- R11: A host write to a mailbox whose flag is already set replaces the byte, and the flag stays set.
- R12: Local addresses 8 (control), 11 (host-to-local mask) and 12 (local-to-host mask) can be written and read back. Addresses 9 (host-to-local flags) and 10 (local-to-host flags) are read-only, with bit i belonging to mailbox i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| hb_data_i | input | 8 | Host data bus, incoming side |
| hb_data_o | output | 8 | Host data bus, outgoing side |
| hb_data_oe | output | 1 | Drive enable for the host data pads |
| hb_sel | input | 3 | Mailbox select from host |
| hb_cs_n | input | 1 | Active-low chip select |
| hb_stba_n | input | 1 | Write enable (mode 0) or write strobe (mode 1), active low |
| hb_stbb_n | input | 1 | Read strobe in mode 1, active low; unused in mode 0 |
| hb_irq_n | output | 1 | Level interrupt to host, active low |
| lc_sel | input | 4 | Local register address |
| lc_wr | input | 1 | Local write request |
| lc_rd | input | 1 | Local read request |
| lc_wdata | input | 8 | Local write data |
| lc_rdata | output | 8 | Local read data, valid the clock after `lc_rd` |
| lc_irq | output | 1 | Interrupt request to local CPU |

## Verification
The assertions check on every cycle how the flags react to events. A decoded host write must set its flag and load the captured byte. A local read with no colliding write must clear its flag, and a same-cycle collision must keep it set. A local write must set the return flag. The global enable must silence both the bus driver and the event decoder. What the properties cannot show is that the asynchronous pin sequences of each bus mode decode to the right event and mailbox through the synchronizers. The bench shows that by driving whole host transfers in both modes, including strobes without chip select, a disabled block and a collision timed to the exact cycle.

// File: rtl/pbus_mailbox_pkg.sv
package pbus_mailbox_pkg;
  // Local register offsets above the mailbox window
  localparam int unsigned OFS_CTRL     = 0;
  localparam int unsigned OFS_H2L_FLAG = 1;
  localparam int unsigned OFS_L2H_FLAG = 2;
  localparam int unsigned OFS_H2L_MASK = 3;
  localparam int unsigned OFS_L2H_MASK = 4;

  // Control register bits
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_MODE = 1;
  localparam int unsigned CTRL_LIE  = 2;
  localparam int unsigned CTRL_W    = 3;

  typedef enum logic {
    BUS_CS_WE    = 1'b0,
    BUS_SPLIT_RW = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pbus_host_decode.sv
module pbus_host_decode
  import pbus_mailbox_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  bus_mode_e     mode,
  input  logic          cs_s,
  input  logic          a_s,
  input  logic          b_s,
  input  logic [SW-1:0] sel_s,
  input  logic [DW-1:0] d_s,
  output logic          ev_wr,
  output logic          ev_rd,
  output logic [SW-1:0] ev_sel,
  output logic [DW-1:0] ev_data,
  output logic          drive
);
  // One more stage: the last value seen before a strobe edge
  logic          cs_q, a_q, b_q;
  logic [SW-1:0] sel_q;
  logic [DW-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      a_q   <= 1'b1;
      b_q   <= 1'b1;
      sel_q <= '0;
      d_q   <= '0;
    end else begin
      cs_q  <= cs_s;
      a_q   <= a_s;
      b_q   <= b_s;
      sel_q <= sel_s;
      d_q   <= d_s;
    end
  end

  logic cs_rise, a_rise, b_rise;
  assign cs_rise = cs_s & ~cs_q;
  assign a_rise  = a_s & ~a_q;
  assign b_rise  = b_s & ~b_q;

  always_comb begin
    ev_wr = 1'b0;
    ev_rd = 1'b0;
    drive = 1'b0;
    if (glb_en) begin
      case (mode)
        BUS_CS_WE: begin
          ev_wr = cs_rise & ~a_q;
          ev_rd = cs_rise & a_q;
          drive = ~cs_s & a_s;
        end
        BUS_SPLIT_RW: begin
          ev_wr = a_rise & ~cs_q;
          ev_rd = b_rise & ~cs_q;
          drive = ~cs_s & ~b_s;
        end
        default: ;
      endcase
    end
  end

  assign ev_sel  = sel_q;
  assign ev_data = d_q;
endmodule

// File: rtl/pbus_mbox_regs.sv
module pbus_mbox_regs
  import pbus_mailbox_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3,
  localparam int unsigned N   = 1 << SW,
  localparam int unsigned LAW = SW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_wr,
  input  logic                  ev_rd,
  input  logic [SW-1:0]         ev_sel,
  input  logic [DW-1:0]         ev_data,
  input  logic [SW-1:0]         host_sel,
  output logic [DW-1:0]         host_rdata,
  input  logic [LAW-1:0]        lc_sel,
  input  logic                  lc_wr,
  input  logic                  lc_rd,
  input  logic [DW-1:0]         lc_wdata,
  output logic [DW-1:0]         lc_rdata,
  output logic                  glb_en,
  output logic                  bus_mode,
  output logic                  lc_irq,
  output logic                  hb_irq_n,
  output logic [N-1:0]          h2l_full,
  output logic [N-1:0]          l2h_full,
  output logic [N-1:0][DW-1:0]  h2l_data
);
  logic [N-1:0][DW-1:0] l2h_data;
  logic [N-1:0]         h2l_mask, l2h_mask;
  logic [CTRL_W-1:0]    ctrl;

  logic          lc_mb;
  logic [SW-1:0] lc_idx;
  assign lc_mb  = ~lc_sel[LAW-1];
  assign lc_idx = lc_sel[SW-1:0];

  // Per-mailbox storage and flags; a set always beats a clear
  for (genvar i = 0; i < N; i++) begin : g_mbox
    logic          hw_hit, hr_hit, lw_hit, lr_hit;
    logic [DW-1:0] h2l_q, l2h_q;
    logic          h2l_f, l2h_f;

    assign hw_hit = ev_wr && (ev_sel == SW'(i));
    assign hr_hit = ev_rd && (ev_sel == SW'(i));
    assign lw_hit = lc_wr && lc_mb && (lc_idx == SW'(i));
    assign lr_hit = lc_rd && lc_mb && (lc_idx == SW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h2l_q <= '0;
        l2h_q <= '0;
        h2l_f <= 1'b0;
        l2h_f <= 1'b0;
      end else begin
        if (hw_hit) h2l_q <= ev_data;
        if (lw_hit) l2h_q <= lc_wdata;
        if (hw_hit)      h2l_f <= 1'b1;
        else if (lr_hit) h2l_f <= 1'b0;
        if (lw_hit)      l2h_f <= 1'b1;
        else if (hr_hit) l2h_f <= 1'b0;
      end
    end

    assign h2l_data[i] = h2l_q;
    assign l2h_data[i] = l2h_q;
    assign h2l_full[i] = h2l_f;
    assign l2h_full[i] = l2h_f;
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      h2l_mask <= '0;
      l2h_mask <= '0;
    end else if (lc_wr && !lc_mb) begin
      case (lc_sel)
        LAW'(N + OFS_CTRL):     ctrl     <= lc_wdata[CTRL_W-1:0];
        LAW'(N + OFS_H2L_MASK): h2l_mask <= lc_wdata[N-1:0];
        LAW'(N + OFS_L2H_MASK): l2h_mask <= lc_wdata[N-1:0];
        default: ;
      endcase
    end
  end

  // Local read data, one clock after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_rdata <= '0;
    end else if (lc_rd) begin
      if (lc_mb) begin
        lc_rdata <= h2l_data[lc_idx];
      end else begin
        case (lc_sel)
          LAW'(N + OFS_CTRL):     lc_rdata <= DW'(ctrl);
          LAW'(N + OFS_H2L_FLAG): lc_rdata <= DW'(h2l_full);
          LAW'(N + OFS_L2H_FLAG): lc_rdata <= DW'(l2h_full);
          LAW'(N + OFS_H2L_MASK): lc_rdata <= DW'(h2l_mask);
          LAW'(N + OFS_L2H_MASK): lc_rdata <= DW'(l2h_mask);
          default:                lc_rdata <= '0;
        endcase
      end
    end
  end

  assign host_rdata = l2h_data[host_sel];
  assign glb_en     = ctrl[CTRL_EN];
  assign bus_mode   = ctrl[CTRL_MODE];
  assign lc_irq     = ctrl[CTRL_LIE] & |(h2l_full & h2l_mask);
  assign hb_irq_n   = ~(ctrl[CTRL_EN] & |(l2h_full & l2h_mask));
endmodule

// File: rtl/pbus_mailbox.sv
module pbus_mailbox
  import pbus_mailbox_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] hb_data_i,
  output logic [DW-1:0] hb_data_o,
  output logic          hb_data_oe,
  input  logic [SW-1:0] hb_sel,
  input  logic          hb_cs_n,
  input  logic          hb_stba_n,
  input  logic          hb_stbb_n,
  output logic          hb_irq_n,
  input  logic [SW:0]   lc_sel,
  input  logic          lc_wr,
  input  logic          lc_rd,
  input  logic [DW-1:0] lc_wdata,
  output logic [DW-1:0] lc_rdata,
  output logic          lc_irq
);
  localparam int unsigned N = 1 << SW;

  // Synchronized host pins
  logic          cs_s, a_s, b_s;
  logic [SW-1:0] sel_s;
  logic [DW-1:0] d_s;

  pbus_sync #(.W(3), .RST_VAL(3'b111)) u_sync_stb (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({hb_cs_n, hb_stba_n, hb_stbb_n}),
    .q   ({cs_s, a_s, b_s})
  );

  pbus_sync #(.W(SW + DW), .RST_VAL('0)) u_sync_dat (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({hb_sel, hb_data_i}),
    .q   ({sel_s, d_s})
  );

  logic          glb_en, bus_mode;
  logic          ev_wr, ev_rd;
  logic [SW-1:0] ev_sel;
  logic [DW-1:0] ev_data;
  logic [N-1:0]  h2l_full, l2h_full;
  logic [N-1:0][DW-1:0] h2l_data;

  pbus_host_decode #(.DW(DW), .SW(SW)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .glb_en  (glb_en),
    .mode    (bus_mode_e'(bus_mode)),
    .cs_s    (cs_s),
    .a_s     (a_s),
    .b_s     (b_s),
    .sel_s   (sel_s),
    .d_s     (d_s),
    .ev_wr   (ev_wr),
    .ev_rd   (ev_rd),
    .ev_sel  (ev_sel),
    .ev_data (ev_data),
    .drive   (hb_data_oe)
  );

  pbus_mbox_regs #(.DW(DW), .SW(SW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_wr      (ev_wr),
    .ev_rd      (ev_rd),
    .ev_sel     (ev_sel),
    .ev_data    (ev_data),
    .host_sel   (sel_s),
    .host_rdata (hb_data_o),
    .lc_sel     (lc_sel),
    .lc_wr      (lc_wr),
    .lc_rd      (lc_rd),
    .lc_wdata   (lc_wdata),
    .lc_rdata   (lc_rdata),
    .glb_en     (glb_en),
    .bus_mode   (bus_mode),
    .lc_irq     (lc_irq),
    .hb_irq_n   (hb_irq_n),
    .h2l_full   (h2l_full),
    .l2h_full   (l2h_full),
    .h2l_data   (h2l_data)
  );
endmodule

// File: rtl/pbus_mailbox_chk.sv
module pbus_mailbox_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3,
  localparam int unsigned N = 1 << SW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SW:0]          lc_sel,
  input logic                 lc_wr,
  input logic                 lc_rd,
  input logic                 lc_irq,
  input logic                 hb_irq_n,
  input logic                 hb_data_oe,
  input logic                 glb_en,
  input logic                 ev_wr,
  input logic                 ev_rd,
  input logic [SW-1:0]        ev_sel,
  input logic [DW-1:0]        ev_data,
  input logic [N-1:0]         h2l_full,
  input logic [N-1:0]         l2h_full,
  input logic [N-1:0][DW-1:0] h2l_data
);
  // R2
  h2l_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> (h2l_full[$past(ev_sel)] && (h2l_data[$past(ev_sel)] == $past(ev_data))));

  // R5
  h2l_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_rd && !lc_sel[SW] && !(ev_wr && (ev_sel == lc_sel[SW-1:0])))
      |=> !h2l_full[$past(lc_sel[SW-1:0])]);

  // R6
  l2h_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_wr && !lc_sel[SW]) |=> l2h_full[$past(lc_sel[SW-1:0])]);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && lc_rd && (lc_sel == {1'b0, ev_sel})) |=> h2l_full[$past(ev_sel)]);

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (!hb_data_oe && !ev_wr && !ev_rd));

  // R8
  host_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_irq_n |-> (glb_en && (l2h_full != '0)));

  // R7
  local_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_irq |-> (h2l_full != '0));
endmodule

bind pbus_mailbox pbus_mailbox_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lc_sel     (lc_sel),
  .lc_wr      (lc_wr),
  .lc_rd      (lc_rd),
  .lc_irq     (lc_irq),
  .hb_irq_n   (hb_irq_n),
  .hb_data_oe (hb_data_oe),
  .glb_en     (glb_en),
  .ev_wr      (ev_wr),
  .ev_rd      (ev_rd),
  .ev_sel     (ev_sel),
  .ev_data    (ev_data),
  .h2l_full   (h2l_full),
  .l2h_full   (l2h_full),
  .h2l_data   (h2l_data)
);

// File: tb/pbus_mailbox_bench.sv
`timescale 1ns/1ps
module pbus_mailbox_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hb_data_i = '0;
  logic [7:0] hb_data_o;
  logic       hb_data_oe;
  logic [2:0] hb_sel = '0;
  logic       hb_cs_n = 1'b1, hb_stba_n = 1'b1, hb_stbb_n = 1'b1;
  logic       hb_irq_n;
  logic [3:0] lc_sel = '0;
  logic       lc_wr = 1'b0, lc_rd = 1'b0;
  logic [7:0] lc_wdata = '0;
  logic [7:0] lc_rdata;
  logic       lc_irq;

  always #4 clk = ~clk;

  pbus_mailbox u_pbus_mailbox (
    .clk (clk), .rst_n (rst_n),
    .hb_data_i (hb_data_i), .hb_data_o (hb_data_o), .hb_data_oe (hb_data_oe),
    .hb_sel (hb_sel), .hb_cs_n (hb_cs_n), .hb_stba_n (hb_stba_n), .hb_stbb_n (hb_stbb_n),
    .hb_irq_n (hb_irq_n),
    .lc_sel (lc_sel), .lc_wr (lc_wr), .lc_rd (lc_rd), .lc_wdata (lc_wdata),
    .lc_rdata (lc_rdata), .lc_irq (lc_irq)
  );

  int unsigned n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference model
  logic [7:0] m_h2l [8];
  logic [7:0] m_l2h [8];
  logic [7:0] m_h2lf = '0, m_l2hf = '0, m_h2lm = '0, m_l2hm = '0;
  logic       m_en = 0, m_mode = 0, m_lie = 0;

  function automatic logic exp_lirq();
    return m_lie & (|(m_h2lf & m_h2lm));
  endfunction
  function automatic logic exp_hirq_n();
    return ~(m_en & (|(m_l2hf & m_l2hm)));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    lc_sel = a; lc_wdata = d; lc_wr = 1'b1;
    @(negedge clk);
    lc_wr = 1'b0;
    if (a < 8) begin m_l2h[a[2:0]] = d; m_l2hf[a[2:0]] = 1'b1; end
    else if (a == 8)  begin m_en = d[0]; m_mode = d[1]; m_lie = d[2]; end
    else if (a == 11) m_h2lm = d;
    else if (a == 12) m_l2hm = d;
  endtask

  task automatic lrd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    lc_sel = a; lc_rd = 1'b1;
    @(negedge clk);
    lc_rd = 1'b0;
    d = lc_rdata;
    if (a < 8) m_h2lf[a[2:0]] = 1'b0;
  endtask

  task automatic set_ctrl(input logic en, input logic mode, input logic lie);
    lwr(4'd8, {5'b0, lie, mode, en});
  endtask

  task automatic hwrite(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    hb_sel = s; hb_data_i = d; hb_cs_n = 1'b0; hb_stba_n = 1'b0;
    repeat (4) @(negedge clk);
    if (!m_mode) begin
      hb_cs_n = 1'b1; @(negedge clk); hb_stba_n = 1'b1;
    end else begin
      hb_stba_n = 1'b1; @(negedge clk); hb_cs_n = 1'b1;
    end
    repeat (4) @(negedge clk);
    if (m_en) begin m_h2l[s] = d; m_h2lf[s] = 1'b1; end
  endtask

  task automatic hread(input logic [2:0] s, output logic [7:0] d, output logic oe);
    @(negedge clk);
    hb_sel = s; hb_cs_n = 1'b0; hb_stba_n = 1'b1;
    if (m_mode) hb_stbb_n = 1'b0;
    repeat (4) @(negedge clk);
    d = hb_data_o; oe = hb_data_oe;
    if (!m_mode) hb_cs_n = 1'b1;
    else begin hb_stbb_n = 1'b1; @(negedge clk); hb_cs_n = 1'b1; end
    repeat (4) @(negedge clk);
    if (m_en) m_l2hf[s] = 1'b0;
  endtask

  task automatic check_flags(input string req);
    logic [7:0] v;
    lrd(4'd9, v);  chk({req, " h2l flags"}, 32'(v), 32'(m_h2lf));
    lrd(4'd10, v); chk({req, " l2h flags"}, 32'(v), 32'(m_l2hf));
  endtask

  task automatic check_irqs();
    chk("R7 lc_irq", 32'(lc_irq), 32'(exp_lirq()));
    chk("R8 hb_irq_n", 32'(hb_irq_n), 32'(exp_hirq_n()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int unsigned seed;
    for (int i = 0; i < 8; i++) begin m_h2l[i] = '0; m_l2h[i] = '0; end
    seed = $urandom(32'h5EED_0B05);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", 32'(hb_data_oe), 0);
    chk("R1 hb_irq_n in reset", 32'(hb_irq_n), 1);
    chk("R1 lc_irq in reset", 32'(lc_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    lrd(4'd8, d);  chk("R1 ctrl", 32'(d), 0);
    lrd(4'd11, d); chk("R1 h2l mask", 32'(d), 0);
    check_flags("R1");

    // R9: disabled block ignores the host
    hwrite(3'd3, 8'h5A);
    hread(3'd3, d, oe);
    chk("R9 no drive when off", 32'(oe), 0);
    check_flags("R9");
    lrd(4'd3, d); chk("R9 mailbox untouched", 32'(d), 0);

    // R12: config readback
    set_ctrl(1'b1, 1'b0, 1'b1);
    lwr(4'd11, 8'hFF);
    lwr(4'd12, 8'hFF);
    lrd(4'd8, d);  chk("R12 ctrl readback", 32'(d), 32'h5);
    lrd(4'd12, d); chk("R12 l2h mask readback", 32'(d), 32'hFF);

    // R2 / R5: mode 0 host write, local read
    hwrite(3'd5, 8'hA7);
    check_flags("R2");
    check_irqs();
    lrd(4'd5, d); chk("R5 local read data", 32'(d), 32'hA7);
    check_flags("R5");
    check_irqs();

    // R6 / R3: local write, mode 0 host read
    lwr(4'd1, 8'h3C);
    check_flags("R6");
    check_irqs();
    hread(3'd1, d, oe);
    chk("R3 host read data", 32'(d), 32'h3C);
    chk("R3 host read drive", 32'(oe), 1);
    check_flags("R3");
    check_irqs();

    // R4: split strobe mode
    set_ctrl(1'b1, 1'b1, 1'b1);
    hwrite(3'd6, 8'hC3);
    lrd(4'd6, d); chk("R4 split write", 32'(d), 32'hC3);
    lwr(4'd7, 8'h81);
    hread(3'd7, d, oe);
    chk("R4 split read data", 32'(d), 32'h81);
    chk("R4 split read drive", 32'(oe), 1);
    check_flags("R4");
    // R4: strobes without chip select do nothing
    lwr(4'd2, 8'h66);
    @(negedge clk);
    hb_sel = 3'd2; hb_data_i = 8'hEE; hb_cs_n = 1'b1; hb_stba_n = 1'b0; hb_stbb_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 no drive without cs", 32'(hb_data_oe), 0);
    hb_stba_n = 1'b1; hb_stbb_n = 1'b1;
    repeat (4) @(negedge clk);
    check_flags("R4 no cs");
    lrd(4'd2, d); chk("R4 no cs data", 32'(d), 32'h00);

    // R11: overwrite of a full mailbox
    set_ctrl(1'b1, 1'b0, 1'b1);
    hwrite(3'd2, 8'h11);
    hwrite(3'd2, 8'h22);
    check_flags("R11");
    lrd(4'd2, d); chk("R11 overwrite data", 32'(d), 32'h22);

    // R10: host write and local read collide in one clock
    hwrite(3'd4, 8'h44);
    @(negedge clk);
    hb_sel = 3'd4; hb_data_i = 8'h99; hb_cs_n = 1'b0; hb_stba_n = 1'b0;
    repeat (4) @(negedge clk);
    hb_cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    lc_sel = 4'd4; lc_rd = 1'b1;
    @(negedge clk);
    lc_rd = 1'b0; hb_stba_n = 1'b1;
    chk("R10 old byte returned", 32'(lc_rdata), 32'h44);
    m_h2l[4] = 8'h99; m_h2lf[4] = 1'b1;
    repeat (4) @(negedge clk);
    check_flags("R10");
    lrd(4'd4, d); chk("R10 new byte kept", 32'(d), 32'h99);

    // R7: mask and enable gating of the local interrupt
    lwr(4'd11, 8'h00);
    hwrite(3'd0, 8'h01);
    check_irqs();
    lwr(4'd11, 8'h01);
    set_ctrl(1'b1, 1'b0, 1'b0);
    check_irqs();
    set_ctrl(1'b1, 1'b0, 1'b1);
    check_irqs();
    lrd(4'd0, d);
    // R8: host interrupt mask
    lwr(4'd12, 8'h00);
    lwr(4'd5, 8'h55);
    check_irqs();
    lwr(4'd12, 8'h20);
    check_irqs();

    // Constrained random mix
    lwr(4'd11, 8'($urandom()));
    lwr(4'd12, 8'($urandom()));
    for (int it = 0; it < 80; it++) begin
      logic [2:0] s;
      logic [7:0] v;
      s = 3'($urandom_range(0, 7));
      v = 8'($urandom());
      case ($urandom_range(0, 5))
        0: hwrite(s, v);
        1: begin
          hread(s, d, oe);
          chk("R3 random host read", 32'(d), 32'(m_l2h[s]));
          chk("R3 random drive", 32'(oe), 1);
        end
        2: lwr({1'b0, s}, v);
        3: begin
          v = m_h2l[s];
          lrd({1'b0, s}, d);
          chk("R5 random local read", 32'(d), 32'(v));
        end
        4: check_flags("R12 random");
        default: set_ctrl(1'b1, 1'($urandom_range(0, 1)), 1'b1);
      endcase
      check_irqs();
    end
    check_flags("R2 final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule